// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller with Default Vector

This block gathers eight interrupt request lines and raises one interrupt line towards a processor. Line 0 has the highest priority and line 7 the lowest. A single global input selects how the lines are read. In edge mode, a low-to-high transition arms a per-line latch, but the line is only counted while that latch is armed and the input is still high. In level mode, a line counts only while it is held high. A mask vector hides lines from arbitration. An in-service register records accepted interrupts and stops lines of equal or lower priority until a non-specific end-of-interrupt pulse retires the highest-priority in-service bit.

When the processor pulses the acknowledge input, the controller looks again at the requests present in that cycle. It does not use the request that first raised the interrupt line. It returns the number of the best eligible line and marks that line in service. If the request has gone away or been masked in the meantime, the controller still has to give an answer. It then returns vector 7 with a default flag and leaves the in-service register as it was. An edge latch whose line was masked at that moment stays armed, so the interrupt is delivered after the mask is lifted.

Top module: `prio_intc`

## Requirements
- R1: On acknowledge, the vector is the lowest-numbered line that is eligible (counted, not masked, and above every in-service level), and that line's in-service bit is set.
- R2: While an in-service bit n is set, lines n..7 neither raise `int_out` nor win an acknowledge.
- R3: A line with a lower number than every set in-service bit raises `int_out` with no end-of-interrupt first.
- R4: If no line is eligible at acknowledge, the vector is 7, `vec_default` is 1 and the in-service register does not change.
- R5: In edge mode, a line counts only after a rising edge has armed its latch and only while the input is still high. A line that was armed and then dropped is not counted.
- R6: A mask bit hides its line but keeps the edge latch armed. After the mask bit is cleared, the line raises `int_out` again and can be acknowledged.
- R7: In level mode (`level_mode`=1), a line counts exactly while its input is high.
- R8: Winning an acknowledge disarms the line's edge latch. A new request on that line needs a low and then a high on the input.
- R9: `int_out` is the registered OR of all eligible lines and appears one clock after the condition. After reset, `int_out`, `vec_valid` and all in-service bits are 0.
- R10: An `eoi` pulse clears the lowest-numbered set in-service bit and no other bit.
- R11: `vec_valid` is high for exactly the one clock after an `inta` pulse. `vec_out`, `vec_default` and the in-service update appear in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines, bit 0 has the highest priority |
| level_mode | input | 1 | 1: level-sensitive lines, 0: edge-armed lines |
| mask | input | 8 | 1 hides the matching line |
| eoi | input | 1 | Non-specific end-of-interrupt pulse |
| inta | input | 1 | Single-cycle acknowledge pulse |
| int_out | output | 1 | Interrupt line to the processor |
| vec_out | output | 3 | Returned vector number |
| vec_valid | output | 1 | Vector strobe, one clock |
| vec_default | output | 1 | Vector is the default 7 |
| isr_out | output | 8 | In-service register |

## Verification
The bench uses the default eight lines. With only eight lines, every request pattern can be swept. In level mode, all 256 patterns are tried under two masks, each followed by one acknowledge. In edge mode, all 256 patterns are armed and then drained by repeated acknowledge and end-of-interrupt steps until only the default vector is left. That drain shows priority order and latch disarming for every subset. Directed sequences then cover nested service, a dropped edge request, a request masked between the interrupt and its acknowledge, and re-arming a line with a low and then a high.

// File: rtl/pic_pkg.sv
package pic_pkg;
  parameter int unsigned PIC_LINES = 8;
  localparam int unsigned VEC_W = $clog2(PIC_LINES);

  typedef logic [PIC_LINES-1:0] line_vec_t;
  typedef logic [VEC_W-1:0]     vec_t;

  // index of the lowest set bit (0 when none)
  function automatic vec_t first_set(line_vec_t v);
    vec_t r;
    r = '0;
    for (int i = PIC_LINES - 1; i >= 0; i--) begin
      if (v[i]) r = vec_t'(i);
    end
    return r;
  endfunction

  // bit i set when no in-service bit at index <= i
  function automatic line_vec_t above_service(line_vec_t isr);
    line_vec_t r;
    logic      blk;
    blk = 1'b0;
    for (int i = 0; i < PIC_LINES; i++) begin
      blk  = blk | isr[i];
      r[i] = ~blk;
    end
    return r;
  endfunction

  // drop the lowest set bit
  function automatic line_vec_t drop_first(line_vec_t v);
    line_vec_t r;
    logic      done;
    r    = v;
    done = 1'b0;
    for (int i = 0; i < PIC_LINES; i++) begin
      if (v[i] && !done) begin
        r[i] = 1'b0;
        done = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic line_vec_t one_hot(vec_t idx);
    return line_vec_t'(1) << idx;
  endfunction
endpackage

// File: rtl/pic_sense.sv
module pic_sense
  import pic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t irq_in,
  input  logic      level_mode,
  input  line_vec_t take,
  output line_vec_t seen
);
  line_vec_t irq_q;
  line_vec_t latch_q;
  line_vec_t rise;

  for (genvar g = 0; g < PIC_LINES; g++) begin : g_line
    assign rise[g] = irq_in[g] & ~irq_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        irq_q[g]   <= 1'b0;
        latch_q[g] <= 1'b0;
      end else begin
        irq_q[g] <= irq_in[g];
        if (take[g])      latch_q[g] <= 1'b0;
        else if (rise[g]) latch_q[g] <= 1'b1;
      end
    end

    // latch output gated by the live input
    assign seen[g] = level_mode ? irq_in[g] : (latch_q[g] & irq_in[g]);
  end

  p_latch_from_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q & ~$past(latch_q) & ~$past(irq_in)) == '0);

  p_take_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take != '0) |=> ((latch_q & $past(take)) == '0));
endmodule

// File: rtl/pic_resolve.sv
module pic_resolve
  import pic_pkg::*;
(
  input  line_vec_t seen,
  input  line_vec_t mask,
  input  line_vec_t isr,
  output logic      any_req,
  output vec_t      winner
);
  line_vec_t eligible;

  assign eligible = seen & ~mask & above_service(isr);
  assign any_req  = |eligible;
  assign winner   = first_set(eligible);
endmodule

// File: rtl/pic_isr_bank.sv
module pic_isr_bank
  import pic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      eoi,
  input  logic      set_en,
  input  vec_t      set_idx,
  output line_vec_t isr_q
);
  line_vec_t after_eoi;
  line_vec_t isr_d;

  assign after_eoi = eoi ? drop_first(isr_q) : isr_q;
  assign isr_d     = after_eoi | (set_en ? one_hot(set_idx) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  p_eoi_drops_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !set_en && isr_q != '0) |=>
      ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import pic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIC_LINES-1:0] irq_in,
  input  logic                 level_mode,
  input  logic [PIC_LINES-1:0] mask,
  input  logic                 eoi,
  input  logic                 inta,
  output logic                 int_out,
  output logic [VEC_W-1:0]     vec_out,
  output logic                 vec_valid,
  output logic                 vec_default,
  output logic [PIC_LINES-1:0] isr_out
);
  line_vec_t seen;
  line_vec_t isr_q;
  line_vec_t take;
  logic      any_req;
  vec_t      winner;
  logic      ack_hit;

  logic      int_q;
  vec_t      vec_q;
  logic      valid_q;
  logic      dflt_q;

  assign ack_hit = inta & any_req;
  assign take    = ack_hit ? one_hot(winner) : '0;

  pic_sense u_sense (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .level_mode (level_mode),
    .take       (take),
    .seen       (seen)
  );

  pic_resolve u_resolve (
    .seen    (seen),
    .mask    (mask),
    .isr     (isr_q),
    .any_req (any_req),
    .winner  (winner)
  );

  pic_isr_bank u_isr (
    .clk     (clk),
    .rst_n   (rst_n),
    .eoi     (eoi),
    .set_en  (ack_hit),
    .set_idx (winner),
    .isr_q   (isr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q   <= 1'b0;
      vec_q   <= '0;
      valid_q <= 1'b0;
      dflt_q  <= 1'b0;
    end else begin
      int_q   <= any_req;
      valid_q <= inta;
      if (inta) begin
        vec_q  <= ack_hit ? winner : vec_t'(PIC_LINES - 1);
        dflt_q <= ~ack_hit;
      end
    end
  end

  assign int_out     = int_q;
  assign vec_out     = vec_q;
  assign vec_valid   = valid_q;
  assign vec_default = dflt_q;
  assign isr_out     = isr_q;

  p_valid_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inta |=> vec_valid);

  p_no_stray_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !inta |=> !vec_valid);

  p_default_is_seven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_default) |-> (vec_out == vec_t'(PIC_LINES - 1)));

  p_default_keeps_isr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_default && !$past(eoi)) |-> (isr_out == $past(isr_out)));

  p_winner_in_service_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_default) |-> isr_out[vec_out]);
endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       level_mode = 1'b0;
  logic [7:0] mask = '0;
  logic       eoi = 1'b0;
  logic       inta = 1'b0;
  logic       int_out;
  logic [2:0] vec_out;
  logic       vec_valid;
  logic       vec_default;
  logic [7:0] isr_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  prio_intc u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_mode),
    .mask(mask), .eoi(eoi), .inta(inta), .int_out(int_out),
    .vec_out(vec_out), .vec_valid(vec_valid), .vec_default(vec_default),
    .isr_out(isr_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_in = '0; mask = '0; eoi = 1'b0; inta = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  // bench model: line i passes when no in-service bit at index <= i
  function automatic logic [7:0] allowed(logic [7:0] isr);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = ((isr & ((8'd2 << i) - 8'd1)) == 0);
    return r;
  endfunction

  function automatic int lowest(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  // pulse acknowledge; expected index -1 means default vector
  task automatic ack_check(input int exp_idx, input logic [7:0] exp_isr, input string req);
    inta = 1'b1;
    step(1);
    inta = 1'b0;
    chk(vec_valid == 1'b1, "R11", "vec_valid", vec_valid, 1);
    if (exp_idx < 0) begin
      chk(vec_default == 1'b1 && vec_out == 3'd7, req, "default vector",
          {vec_default, vec_out}, 4'hF);
    end else begin
      chk(vec_default == 1'b0 && int'(vec_out) == exp_idx, req, "vector",
          {vec_default, vec_out}, exp_idx);
    end
    chk(isr_out == exp_isr, req, "isr", isr_out, exp_isr);
    step(1);
    chk(vec_valid == 1'b0, "R11", "vec_valid drop", vec_valid, 0);
  endtask

  task automatic eoi_pulse();
    eoi = 1'b1;
    step(1);
    eoi = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_isr;
    logic [7:0] remaining;

    do_reset();
    // R9: reset state
    chk(int_out == 1'b0, "R9", "int after reset", int_out, 0);
    chk(vec_valid == 1'b0, "R9", "valid after reset", vec_valid, 0);
    chk(isr_out == 8'h00, "R9", "isr after reset", isr_out, 0);

    // R7 R1 R4 R9 R10: level sweep over all patterns and two masks
    level_mode = 1'b1;
    for (int mi = 0; mi < 2; mi++) begin
      for (int p = 0; p < 256; p++) begin
        logic [7:0] elig;
        int         w;
        irq_in = 8'(p);
        mask   = (mi == 0) ? 8'h00 : 8'hA5;
        elig   = irq_in & ~mask;
        w      = lowest(elig);
        step(1);
        chk(int_out == (elig != 0), "R7", "level int", int_out, elig != 0);
        ack_check(w, (w < 0) ? 8'h00 : (8'd1 << w), (w < 0) ? "R4" : "R1");
        if (w >= 0) begin
          eoi_pulse();
          chk(isr_out == 8'h00, "R10", "isr after eoi", isr_out, 0);
        end
        irq_in = '0;
        step(1);
      end
    end
    step(1);
    chk(int_out == 1'b0, "R7", "level int idle", int_out, 0);

    // R5 R8 R1 R2: edge sweep, arm a pattern and drain it
    level_mode = 1'b0;
    mask = '0;
    for (int p = 0; p < 256; p++) begin
      irq_in = '0;
      step(2);
      irq_in = 8'(p);
      step(2);
      remaining = 8'(p);
      while (remaining != 0) begin
        int w;
        w = lowest(remaining);
        chk(int_out == 1'b1, "R5", "edge int", int_out, 1);
        ack_check(w, 8'd1 << w, "R1");
        step(1);
        chk(int_out == 1'b0, "R2", "blocked by service", int_out, 0);
        eoi_pulse();
        remaining[w] = 1'b0;
        step(1);
      end
      chk(int_out == 1'b0, "R8", "drained int", int_out, 0);
      ack_check(-1, 8'h00, "R8");
    end

    // R2 R3 R10: nested service in level mode
    do_reset();
    level_mode = 1'b1;
    exp_isr = 8'h00;
    irq_in = 8'h08;
    step(1);
    exp_isr = 8'h08;
    ack_check(3, exp_isr, "R1");
    step(1);
    chk(int_out == 1'b0, "R2", "same line blocked", int_out, 0);
    irq_in = 8'h28;
    step(2);
    chk(int_out == 1'b0, "R2", "lower line blocked", int_out, 0);
    chk((allowed(exp_isr) & irq_in) == 0, "R2", "model blocked", 0, 0);
    irq_in = 8'h2A;
    step(2);
    chk(int_out == 1'b1, "R3", "higher line passes", int_out, 1);
    exp_isr = 8'h0A;
    ack_check(1, exp_isr, "R3");
    eoi_pulse();
    chk(isr_out == 8'h08, "R10", "eoi clears line 1", isr_out, 8'h08);
    eoi_pulse();
    chk(isr_out == 8'h00, "R10", "eoi clears line 3", isr_out, 0);
    irq_in = '0;

    // R5 R4: edge request dropped before acknowledge
    do_reset();
    level_mode = 1'b0;
    irq_in = 8'h10;
    step(2);
    chk(int_out == 1'b1, "R5", "armed edge int", int_out, 1);
    irq_in = 8'h00;
    step(1);
    ack_check(-1, 8'h00, "R5");
    step(1);
    chk(int_out == 1'b0, "R5", "dropped line unseen", int_out, 0);

    // R6 R8: masked between interrupt and acknowledge
    do_reset();
    level_mode = 1'b0;
    irq_in = 8'h04;
    step(2);
    chk(int_out == 1'b1, "R6", "edge int before mask", int_out, 1);
    mask = 8'h04;
    ack_check(-1, 8'h00, "R4");
    chk(int_out == 1'b0, "R6", "masked int", int_out, 0);
    mask = 8'h00;
    step(2);
    chk(int_out == 1'b1, "R6", "latch kept after unmask", int_out, 1);
    ack_check(2, 8'h04, "R6");
    eoi_pulse();
    step(2);
    chk(int_out == 1'b0, "R8", "held high not re-armed", int_out, 0);
    irq_in = 8'h00;
    step(1);
    irq_in = 8'h04;
    step(2);
    chk(int_out == 1'b1, "R8", "re-armed by new edge", int_out, 1);
    ack_check(2, 8'h04, "R8");

    // R7: level line dropped before acknowledge
    do_reset();
    level_mode = 1'b1;
    irq_in = 8'h40;
    step(1);
    chk(int_out == 1'b1, "R7", "level int raised", int_out, 1);
    irq_in = 8'h00;
    ack_check(-1, 8'h00, "R7");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule